// File: doc/BRIEF.md
# Priority Round-Robin Arbiter with Grant Bursts

This block arbitrates eight requesters that share one transaction interface. Each requester raises a request line and presents a priority level. In every cycle where issue is allowed, the arbiter grants the highest-priority requester. Ties at the top level are broken by a rotating pointer. The grant is registered and lasts one cycle per transaction issued.

Among tied requesters, the winner can keep the grant for a short run of back-to-back grants before the pointer moves past it. A three-bit control write port selects a run of one, two or four grants. The same port can serialise the interface so that only one transaction is in flight. Otherwise, up to four grants may be outstanding at once, and each one is retired by a single-cycle done pulse.

Top module: `burst_rr_arbiter`

## Requirements
- R1: After reset the control state is: double-run on, quadruple-run off, pipelined issue. With no write, two equal-priority requesters therefore receive grants in pairs.
- R2: The requester with the numerically largest priority value wins, and a run in progress never delays it. Priority is a 2-bit field per requester, and requester i uses prio_i[2i+1:2i].
- R3: Among equal top-priority requesters, the search starts just after the last winner and wraps from requester 7 to requester 0. The search starts at requester 0 after reset.
- R4: With double-run on and quadruple-run off, the tie winner gets at most two grants in a row before the pointer moves on.
- R5: With quadruple-run on, the tie winner gets at most four grants in a row, whatever the double-run bit is set to.
- R6: With both run bits off, every grant moves the pointer, so tied requesters alternate.
- R7: When the current winner drops its request, its run ends at once and the next grant goes to the next tied requester after it.
- R8: With serialise on, no grant is issued while a transaction is outstanding. A done pulse lets the next grant issue one cycle later.
- R9: In pipelined mode, the outstanding count rises on each grant and falls on each done, and issue stops at four. A grant and a done in the same cycle leave the count unchanged. A done with nothing outstanding is ignored.
- R10: grant_o is one-hot or zero, and it is zero in any cycle that follows a cycle with no request or with issue blocked.
- R11: A write with cfg_we high takes effect from the next cycle. cfg_wdata bit 0 is double-run, bit 1 is quadruple-run and bit 2 is serialise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 8 | Request line per requester |
| prio_i | input | 16 | Packed 2-bit priority per requester |
| cfg_we | input | 1 | Control write strobe |
| cfg_wdata | input | 3 | Control bits: double-run, quadruple-run, serialise |
| done_i | input | 1 | One-cycle pulse retiring one outstanding transaction |
| grant_o | output | 8 | Registered one-hot grant |

## Verification
A new grant and the retirement of an older transaction can land on the same clock edge. The outstanding counter must then hold its value rather than count up or down. The bench provokes this by holding done high while all eight requesters ask continuously in pipelined mode. It judges the result by a full 0-to-7 rotation with no blocked cycle; the counter would stall that rotation after four grants if it were handled wrongly. Separate scenarios with done held low confirm that the cap of four and the serialised cap of one do block.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef struct packed {
    logic serial;
    logic quad;
    logic dbl;
  } arb_cfg_t;

  localparam arb_cfg_t CFG_RESET = '{serial: 1'b0, quad: 1'b0, dbl: 1'b1};

  function automatic logic [2:0] run_limit(input arb_cfg_t c);
    if (c.quad)     return 3'd4;
    else if (c.dbl) return 3'd2;
    else            return 3'd1;
  endfunction

endpackage

// File: rtl/arb_cfg_reg.sv
module arb_cfg_reg
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [2:0] wdata,
  output arb_cfg_t   cfg
);

  always_ff @(posedge clk) begin
    if (rst)     cfg <= CFG_RESET;
    else if (we) cfg <= arb_cfg_t'(wdata);
  end

  assert_reset_cfg_R1: assert property (@(posedge clk)
    rst |=> (cfg.dbl && !cfg.quad && !cfg.serial));

endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int N  = 8,
  parameter int PW = 2,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]    req,
  input  logic [N*PW-1:0] prio,
  input  logic [IW-1:0]   ptr,
  output logic [N-1:0]    cand,
  output logic [IW-1:0]   rr_idx,
  output logic            any
);

  logic [PW-1:0] top;

  always_comb begin
    top = '0;
    for (int i = 0; i < N; i++)
      if (req[i] && prio[i*PW +: PW] > top) top = prio[i*PW +: PW];
  end

  for (genvar g = 0; g < N; g++) begin : g_cand
    assign cand[g] = req[g] && (prio[g*PW +: PW] == top);
  end

  assign any = |req;

  always_comb begin
    logic found;
    int   pos;
    found  = 1'b0;
    rr_idx = '0;
    for (int k = 0; k < N; k++) begin
      pos = int'(ptr) + k;
      if (pos >= N) pos = pos - N;
      if (!found && cand[pos]) begin
        rr_idx = IW'(pos);
        found  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/arb_burst.sv
module arb_burst #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  cand,
  input  logic [IW-1:0] rr_idx,
  input  logic [2:0]    limit,
  input  logic          issue,
  output logic [IW-1:0] win_idx,
  output logic [IW-1:0] ptr
);

  logic [IW-1:0] owner;
  logic          owner_v;
  logic [2:0]    run_cnt;
  logic          sticky;

  assign sticky  = owner_v && cand[owner] && (run_cnt < limit);
  assign win_idx = sticky ? owner : rr_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      owner   <= '0;
      owner_v <= 1'b0;
      run_cnt <= '0;
      ptr     <= '0;
    end else if (issue) begin
      owner   <= win_idx;
      owner_v <= 1'b1;
      run_cnt <= sticky ? run_cnt + 3'd1 : 3'd1;
      ptr     <= (win_idx == IW'(N-1)) ? '0 : win_idx + IW'(1);
    end else if (owner_v && !req[owner]) begin
      owner_v <= 1'b0;
      run_cnt <= '0;
    end
  end

  assert_run_bound_R5: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= 3'd4);

  assert_drop_ends_run_R7: assert property (@(posedge clk) disable iff (rst)
    (owner_v && !req[owner] && !issue) |=> !owner_v);

endmodule

// File: rtl/arb_issue_gate.sv
module arb_issue_gate #(
  parameter int MAX_OUT = 4,
  localparam int CW = $clog2(MAX_OUT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          serial,
  input  logic          want,
  input  logic          done,
  output logic          issue,
  output logic [CW-1:0] out_cnt
);

  logic [CW-1:0] cap;
  logic          retire;

  assign cap    = serial ? CW'(1) : CW'(MAX_OUT);
  assign issue  = want && (out_cnt < cap);
  assign retire = done && (out_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) out_cnt <= '0;
    else     out_cnt <= out_cnt + CW'(issue) - CW'(retire);
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    out_cnt <= CW'(MAX_OUT));

  assert_balanced_R9: assert property (@(posedge clk) disable iff (rst)
    (issue && retire) |=> $stable(out_cnt));

endmodule

// File: rtl/burst_rr_arbiter.sv
module burst_rr_arbiter
  import arb_pkg::*;
#(
  parameter int N       = 8,
  parameter int PW      = 2,
  parameter int MAX_OUT = 4,
  localparam int IW = $clog2(N),
  localparam int CW = $clog2(MAX_OUT + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    req_i,
  input  logic [N*PW-1:0] prio_i,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_wdata,
  input  logic            done_i,
  output logic [N-1:0]    grant_o
);

  arb_cfg_t      cfg;
  logic [N-1:0]  cand;
  logic [IW-1:0] rr_idx, win_idx, ptr;
  logic          any, issue;
  logic [CW-1:0] out_cnt;

  arb_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .cfg(cfg)
  );

  arb_pick #(.N(N), .PW(PW)) u_pick (
    .req(req_i), .prio(prio_i), .ptr(ptr),
    .cand(cand), .rr_idx(rr_idx), .any(any)
  );

  arb_burst #(.N(N)) u_burst (
    .clk(clk), .rst(rst), .req(req_i), .cand(cand), .rr_idx(rr_idx),
    .limit(run_limit(cfg)), .issue(issue), .win_idx(win_idx), .ptr(ptr)
  );

  arb_issue_gate #(.MAX_OUT(MAX_OUT)) u_gate (
    .clk(clk), .rst(rst), .serial(cfg.serial), .want(any),
    .done(done_i), .issue(issue), .out_cnt(out_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst)        grant_o <= '0;
    else if (issue) grant_o <= N'(1) << win_idx;
    else            grant_o <= '0;
  end

  assert_onehot_grant_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));

  assert_idle_no_grant_R10: assert property (@(posedge clk) disable iff (rst)
    !(|req_i) |=> (grant_o == '0));

  assert_serial_block_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg.serial && out_cnt != '0) |=> (grant_o == '0));

endmodule

// File: tb/sim_burst_rr_arbiter.sv
`timescale 1ns/100ps
module sim_burst_rr_arbiter;

  localparam int N  = 8;
  localparam int PW = 2;

  logic            clk = 1'b0;
  logic            rst;
  logic [N-1:0]    req;
  logic [N*PW-1:0] prio;
  logic            cfg_we;
  logic [2:0]      cfg_wdata;
  logic            done;
  logic [N-1:0]    grant;

  int nchk = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  burst_rr_arbiter u0 (
    .clk(clk), .rst(rst), .req_i(req), .prio_i(prio), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .done_i(done), .grant_o(grant)
  );

  function automatic int gidx(input logic [N-1:0] g);
    if (g == '0) return -1;
    if (!$onehot(g)) return -2;
    for (int i = 0; i < N; i++) if (g[i]) return i;
    return -2;
  endfunction

  task automatic chk_g(input string tag, input int e);
    int a;
    @(negedge clk);
    a = gidx(grant);
    nchk++;
    if (a != e) begin
      nerr++;
      $display("FAIL %s grant index actual=%0d expected=%0d", tag, a, e);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req = '0; prio = '0; done = 1'b0;
    cfg_we = 1'b0; cfg_wdata = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr_cfg(input logic [2:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setp(input int i, input int p);
    prio[i*PW +: PW] = PW'(p);
  endtask

  task automatic t_reset_idle();
    do_reset();
    nchk++;
    if (grant != '0) begin
      nerr++;
      $display("FAIL R10 reset grant actual=%0h expected=0", grant);
    end
    chk_g("R10 idle", -1);
    chk_g("R10 idle", -1);
  endtask

  task automatic t_default_pairs();
    do_reset();
    done = 1'b1;
    req = 8'b0000_0011;
    chk_g("R1 R4", 0); chk_g("R1 R4", 0);
    chk_g("R1 R4", 1); chk_g("R1 R4", 1);
    chk_g("R1 R4", 0); chk_g("R1 R4", 0);
  endtask

  task automatic t_single_step();
    do_reset();
    done = 1'b1;
    wr_cfg(3'b000);
    req = 8'b0000_0011;
    chk_g("R6 R11", 0); chk_g("R6 R11", 1);
    chk_g("R6 R11", 0); chk_g("R6 R11", 1);
  endtask

  task automatic t_quad();
    do_reset();
    done = 1'b1;
    wr_cfg(3'b011);
    req = 8'b0010_0100;
    for (int k = 0; k < 4; k++) chk_g("R5", 2);
    for (int k = 0; k < 4; k++) chk_g("R5", 5);
    chk_g("R5", 2);
  endtask

  task automatic t_wrap();
    do_reset();
    done = 1'b1;
    wr_cfg(3'b000);
    req = 8'b1100_0010;
    chk_g("R3", 1); chk_g("R3", 6); chk_g("R3", 7);
    chk_g("R3 wrap", 1); chk_g("R3", 6);
  endtask

  task automatic t_priority();
    do_reset();
    done = 1'b1;
    setp(0, 1); setp(1, 1); setp(3, 2);
    req = 8'b0000_1011;
    chk_g("R2", 3); chk_g("R2", 3); chk_g("R2", 3);
    req[3] = 1'b0;
    chk_g("R2 R3", 0); chk_g("R2 R4", 0); chk_g("R2 R4", 1);
    do_reset();
    done = 1'b1;
    setp(0, 1); setp(1, 1); setp(3, 2);
    req = 8'b0000_0011;
    chk_g("R2", 0);
    req[3] = 1'b1;
    chk_g("R2 preempt", 3);
  endtask

  task automatic t_drop();
    do_reset();
    done = 1'b1;
    req = 8'b0000_0111;
    chk_g("R7", 0);
    req[0] = 1'b0;
    chk_g("R7", 1); chk_g("R7", 1);
    chk_g("R7", 2); chk_g("R7", 2);
    chk_g("R7", 1);
  endtask

  task automatic t_serial();
    do_reset();
    wr_cfg(3'b100);
    req = 8'b0000_0001;
    chk_g("R8", 0); chk_g("R8", -1); chk_g("R8", -1);
    done = 1'b1;
    chk_g("R8", -1);
    done = 1'b0;
    chk_g("R8", 0); chk_g("R8", -1);
  endtask

  task automatic t_pipe_cap();
    do_reset();
    req = 8'b0000_0011;
    chk_g("R9", 0); chk_g("R9", 0); chk_g("R9", 1); chk_g("R9", 1);
    chk_g("R9 cap", -1); chk_g("R9 cap", -1);
    done = 1'b1;
    chk_g("R9", -1);
    done = 1'b0;
    chk_g("R9", 0); chk_g("R9 cap", -1);
  endtask

  task automatic t_overlap();
    do_reset();
    done = 1'b1;
    wr_cfg(3'b000);
    req = '1;
    for (int k = 0; k < N; k++) chk_g("R9 overlap", k);
    chk_g("R9 overlap", 0);
  endtask

  initial begin
    rst = 1'b1; req = '0; prio = '0; done = 1'b0;
    cfg_we = 1'b0; cfg_wdata = '0;
    t_reset_idle();
    t_default_pairs();
    t_single_step();
    t_quad();
    t_wrap();
    t_priority();
    t_drop();
    t_serial();
    t_pipe_cap();
    t_overlap();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog R10 actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule